// File: doc/BRIEF.md
# AUX Request Framer

This block prepares one DisplayPort AUX request for the line side. A request arrives as a single-cycle strobe with a 20-bit target address, a read/write flag, a native/I2C flag, a flag for a missing data buffer and a byte length. The block first sorts the request into one of three classes. Address-only requests complete at once with an acknowledge. Oversized requests are refused. All other requests are loaded into an internal byte FIFO, which is emptied on acceptance.

The FIFO receives a four-byte header, followed by the payload bytes pulled from a byte-stream source when the request is a write. A one-cycle go strobe then starts the transfer. It carries three transaction-control flags: I2C, suppress-address and suppress-stop. The line side drains the FIFO through a valid/ready byte port.

When the line side returns reply words, each made of a data byte and an 8-bit index, the block discards the first word. It forwards data bytes while each index matches its position and stops at the first mismatch. When the line side signals completion, the block reports how many bytes were good.

Top module: `aux_req_framer`

## Requirements
- R1: Loaded header bytes, in FIFO order: byte 0 is {3'b000, read flag, address[19:16]}, byte 1 is address[15:8], byte 2 is address[7:0], and byte 3 is length minus one.
- R2: For a write, exactly `length` payload bytes follow the header in arrival order. For a read, only the four header bytes are loaded. After the last loaded byte, tx_valid is low.
- R3: A request is refused if it is native with length above 16, if its length is above 128, or if it is a write with length above 124. A refused request gives done with kind 2, loads nothing, raises no go and leaves busy low.
- R4: A request of length zero, or one with req_nobuf set, is address-only, and this check takes precedence over R3. It gives done with kind 1 one cycle after acceptance, with no go and busy low.
- R5: go is a one-cycle pulse. With it, go_i2c is high for I2C requests, go_no_addr is high for I2C requests, and go_no_stop is high for I2C writes. All three flags are low for native requests.
- R6: Accepting a loaded request empties the FIFO. Bytes left undrained by the previous transfer are never sent.
- R7: In a read, the first reply word is dropped. Reply word k (k ≥ 1) is forwarded on rsp_valid/rsp_data one cycle after it arrives, but only while its index equals k-1, every earlier index matched, and k-1 is below the length. Forwarding stops at the first mismatch. Reply words that arrive together with ln_done are ignored.
- R8: busy rises on the edge that accepts a loaded request and falls on the edge that samples ln_done. Requests presented while busy is high are ignored.
- R9: done is a one-cycle pulse. Its kind code is 0 for a completed transfer, 1 for address-only and 2 for refused. The done count is the number of forwarded bytes for a read, the length for a write, and 0 for the other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_native | input | 1 | 1 = native request, 0 = I2C-over-AUX |
| req_read | input | 1 | 1 = read, 0 = write |
| req_nobuf | input | 1 | Request has no data buffer |
| req_addr | input | 20 | Target address |
| req_len | input | 8 | Transfer length in bytes |
| pl_ready | output | 1 | Block takes a payload byte |
| pl_valid | input | 1 | Payload byte present |
| pl_data | input | 8 | Payload byte |
| go | output | 1 | Transaction start pulse |
| go_i2c | output | 1 | I2C transaction flag |
| go_no_addr | output | 1 | Suppress-address flag |
| go_no_stop | output | 1 | Suppress-stop flag |
| busy | output | 1 | Transfer in progress |
| tx_valid | output | 1 | FIFO byte available to line side |
| tx_data | output | 8 | FIFO byte |
| tx_ready | input | 1 | Line side takes the byte |
| rx_valid | input | 1 | Reply word present |
| rx_data | input | 8 | Reply data byte |
| rx_idx | input | 8 | Reply word index |
| ln_done | input | 1 | Line side completion |
| rsp_valid | output | 1 | Forwarded reply byte valid |
| rsp_data | output | 8 | Forwarded reply byte |
| done | output | 1 | Request completion pulse |
| done_kind | output | 2 | 0 transfer, 1 address-only, 2 refused |
| done_count | output | 8 | Good byte count or write length |

## Verification
The bench tests the exact boundaries of the size limits: 16 and 17 bytes for a native request, 124 and 125 bytes for a write, and 128 and 129 bytes for a read. A design with an off-by-one in any of these would refuse a legal request or load an oversized one. It also sends an address-only request with a huge length. A design that checks size before the address-only condition would report a refusal there.

Reply streams include a bad index in mid-stream and a stream shorter than the length. A design that skips the dropped first word, or keeps forwarding after a mismatch, produces wrong bytes or a wrong count.

One transfer is drained only partly and is followed by a read. A design that does not clear the FIFO would send stale bytes ahead of the new header.

A zero-length request is presented while the block is busy. A design that accepts it would produce an address-only done in the middle of a transfer.

// File: rtl/aux_framer_pkg.sv
package aux_framer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_GO,
    ST_WAIT
  } fr_state_e;

  typedef enum logic [1:0] {
    RQ_LOAD,
    RQ_ADDR_ONLY,
    RQ_REJECT
  } req_class_e;

  typedef enum logic [1:0] {
    DK_XFER      = 2'd0,
    DK_ADDR_ONLY = 2'd1,
    DK_REJECT    = 2'd2
  } done_kind_e;

endpackage

// File: rtl/aux_req_check.sv
module aux_req_check
  import aux_framer_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int HDR_BYTES  = 4,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int CMD_MAX    = 128
) (
  input  logic             native,
  input  logic             read,
  input  logic             nobuf,
  input  logic [LEN_W-1:0] len,
  output req_class_e       cls,
  output logic             f_i2c,
  output logic             f_no_addr,
  output logic             f_no_stop
);
  localparam logic [LEN_W-1:0] NAT_LIM = LEN_W'(NATIVE_MAX);
  localparam logic [LEN_W-1:0] I2C_LIM = LEN_W'(I2C_MAX);
  localparam logic [LEN_W-1:0] WR_LIM  = LEN_W'(CMD_MAX - HDR_BYTES);

  logic too_big;

  always_comb begin
    too_big = (native && (len > NAT_LIM)) || (len > I2C_LIM) ||
              (!read && (len > WR_LIM));
    if ((len == '0) || nobuf) begin
      cls = RQ_ADDR_ONLY;
    end else if (too_big) begin
      cls = RQ_REJECT;
    end else begin
      cls = RQ_LOAD;
    end
    f_i2c     = !native;
    f_no_addr = !native;
    f_no_stop = !native && !read;
  end

endmodule

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
  parameter int DEPTH = 144,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_wr    = wr_en && (cnt_q != FULL) && !clr;
    do_rd    = rd_en && (cnt_q != '0) && !clr;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_wr) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_rd) rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr_q] <= wr_data;
  end

  assign rd_data = mem[rd_ptr_q];
  assign empty   = (cnt_q == '0);

endmodule

// File: rtl/aux_reply_scan.sv
module aux_reply_scan #(
  parameter int LEN_W = 8,
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic [LEN_W-1:0] len,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic [LEN_W-1:0] good_cnt
);
  logic             seen_q, seen_d;
  logic             halt_q, halt_d;
  logic [LEN_W-1:0] pos_q, pos_d;
  logic             rv_q, rv_d;
  logic [DW-1:0]    rd_q, rd_d;

  always_comb begin
    seen_d = seen_q;
    halt_d = halt_q;
    pos_d  = pos_q;
    rv_d   = 1'b0;
    rd_d   = rd_q;
    if (clr) begin
      seen_d = 1'b0;
      halt_d = 1'b0;
      pos_d  = '0;
    end else if (en && rx_valid) begin
      if (!seen_q) begin
        seen_d = 1'b1;
      end else if (!halt_q && (pos_q < len)) begin
        if (rx_idx == IDX_W'(pos_q)) begin
          rv_d  = 1'b1;
          rd_d  = rx_data;
          pos_d = pos_q + 1'b1;
        end else begin
          halt_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      halt_q <= 1'b0;
      pos_q  <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      seen_q <= seen_d;
      halt_q <= halt_d;
      pos_q  <= pos_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;
  assign good_cnt  = pos_q;

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_framer_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int LEN_W      = 8,
  parameter int IDX_W      = 8,
  parameter int FIFO_DEPTH = 144,
  parameter int HDR_BYTES  = 4,
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int CMD_MAX    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_native,
  input  logic              req_read,
  input  logic              req_nobuf,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              pl_ready,
  input  logic              pl_valid,
  input  logic [7:0]        pl_data,
  output logic              go,
  output logic              go_i2c,
  output logic              go_no_addr,
  output logic              go_no_stop,
  output logic              busy,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              ln_done,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic              done,
  output logic [1:0]        done_kind,
  output logic [LEN_W-1:0]  done_count
);
  localparam int HCNT_W = $clog2(HDR_BYTES);
  localparam logic [HCNT_W-1:0] HDR_LAST = HCNT_W'(HDR_BYTES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  fr_state_e         state_q, state_d;
  logic [HCNT_W-1:0] hcnt_q, hcnt_d;
  logic [LEN_W-1:0]  pcnt_q, pcnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              read_q, i2c_q, noaddr_q, nostop_q;
  logic              done_q, done_d;
  done_kind_e        kind_q, kind_d;
  logic [LEN_W-1:0]  dcnt_q, dcnt_d;
  logic              load_en, fifo_clr, fifo_wr, fifo_rd, fifo_empty;
  logic [7:0]        fifo_wdata, hdr_byte;
  logic [LEN_W-1:0]  good_cnt;
  req_class_e        cls;
  logic              f_i2c, f_no_addr, f_no_stop;

  aux_req_check #(
    .LEN_W(LEN_W), .HDR_BYTES(HDR_BYTES), .NATIVE_MAX(NATIVE_MAX),
    .I2C_MAX(I2C_MAX), .CMD_MAX(CMD_MAX)
  ) i_check (
    .native(req_native), .read(req_read), .nobuf(req_nobuf), .len(req_len),
    .cls(cls), .f_i2c(f_i2c), .f_no_addr(f_no_addr), .f_no_stop(f_no_stop)
  );

  aux_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
    .clk(clk), .rst_n(rst_l), .clr(fifo_clr), .wr_en(fifo_wr),
    .wr_data(fifo_wdata), .rd_en(fifo_rd), .rd_data(tx_data),
    .empty(fifo_empty)
  );

  aux_reply_scan #(.LEN_W(LEN_W), .IDX_W(IDX_W), .DW(8)) i_scan (
    .clk(clk), .rst_n(rst_l), .clr(fifo_clr),
    .en((state_q == ST_WAIT) && read_q && !ln_done),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx), .len(len_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .good_cnt(good_cnt)
  );

  always_comb begin
    case (hcnt_q)
      HCNT_W'(0): hdr_byte = {3'b000, read_q, addr_q[ADDR_W-1 -: 4]};
      HCNT_W'(1): hdr_byte = addr_q[15:8];
      HCNT_W'(2): hdr_byte = addr_q[7:0];
      default:    hdr_byte = 8'(len_q - 1'b1);
    endcase
  end

  always_comb begin
    state_d    = state_q;
    hcnt_d     = hcnt_q;
    pcnt_d     = pcnt_q;
    done_d     = 1'b0;
    kind_d     = kind_q;
    dcnt_d     = dcnt_q;
    load_en    = 1'b0;
    fifo_clr   = 1'b0;
    fifo_wr    = 1'b0;
    fifo_wdata = hdr_byte;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (cls)
            RQ_ADDR_ONLY: begin
              done_d = 1'b1;
              kind_d = DK_ADDR_ONLY;
              dcnt_d = '0;
            end
            RQ_REJECT: begin
              done_d = 1'b1;
              kind_d = DK_REJECT;
              dcnt_d = '0;
            end
            default: begin
              load_en  = 1'b1;
              fifo_clr = 1'b1;
              hcnt_d   = '0;
              pcnt_d   = '0;
              state_d  = ST_HDR;
            end
          endcase
        end
      end
      ST_HDR: begin
        fifo_wr = 1'b1;
        hcnt_d  = hcnt_q + 1'b1;
        if (hcnt_q == HDR_LAST) state_d = read_q ? ST_GO : ST_PAY;
      end
      ST_PAY: begin
        if (pl_valid) begin
          fifo_wr    = 1'b1;
          fifo_wdata = pl_data;
          pcnt_d     = pcnt_q + 1'b1;
          if (pcnt_q == LEN_W'(len_q - 1'b1)) state_d = ST_GO;
        end
      end
      ST_GO: state_d = ST_WAIT;
      ST_WAIT: begin
        if (ln_done) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          kind_d  = DK_XFER;
          dcnt_d  = read_q ? good_cnt : len_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
      kind_q  <= DK_XFER;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      pcnt_q  <= pcnt_d;
      done_q  <= done_d;
      kind_q  <= kind_d;
      dcnt_q  <= dcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      addr_q   <= '0;
      len_q    <= '0;
      read_q   <= 1'b0;
      i2c_q    <= 1'b0;
      noaddr_q <= 1'b0;
      nostop_q <= 1'b0;
    end else if (load_en) begin
      addr_q   <= req_addr;
      len_q    <= req_len;
      read_q   <= req_read;
      i2c_q    <= f_i2c;
      noaddr_q <= f_no_addr;
      nostop_q <= f_no_stop;
    end
  end

  assign fifo_rd    = (state_q == ST_WAIT) && tx_ready;
  assign tx_valid   = (state_q == ST_WAIT) && !fifo_empty;
  assign pl_ready   = (state_q == ST_PAY);
  assign go         = (state_q == ST_GO);
  assign go_i2c     = i2c_q;
  assign go_no_addr = noaddr_q;
  assign go_no_stop = nostop_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign done_kind  = kind_q;
  assign done_count = dcnt_q;

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       go,
  input logic       pl_ready,
  input logic       tx_valid,
  input logic       rsp_valid,
  input logic       done,
  input logic [1:0] done_kind
);
  // R5
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  // R5
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> busy);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R3
  quick_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_kind != 2'd0)) |-> !busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  tx_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || pl_ready) |-> busy);
  // R7
  rsp_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy);
  // R9
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_kind != 2'd3));
endmodule

bind aux_req_framer aux_req_framer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .go(go),
  .pl_ready(pl_ready), .tx_valid(tx_valid), .rsp_valid(rsp_valid),
  .done(done), .done_kind(done_kind)
);

// File: tb/test_aux_req_framer.sv
module test_aux_req_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_native = 1'b0, req_read = 1'b0, req_nobuf = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic pl_valid = 1'b0;
  logic [7:0] pl_data = '0;
  logic tx_ready = 1'b0, rx_valid = 1'b0, ln_done = 1'b0;
  logic [7:0] rx_data = '0, rx_idx = '0;
  logic pl_ready, go, go_i2c, go_no_addr, go_no_stop, busy, tx_valid;
  logic [7:0] tx_data, rsp_data, done_count;
  logic rsp_valid, done;
  logic [1:0] done_kind;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  aux_req_framer i_aux_req_framer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_native(req_native),
    .req_read(req_read), .req_nobuf(req_nobuf), .req_addr(req_addr),
    .req_len(req_len), .pl_ready(pl_ready), .pl_valid(pl_valid),
    .pl_data(pl_data), .go(go), .go_i2c(go_i2c), .go_no_addr(go_no_addr),
    .go_no_stop(go_no_stop), .busy(busy), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_idx(rx_idx), .ln_done(ln_done),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done),
    .done_kind(done_kind), .done_count(done_count)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // one request through the reference model
  task automatic run_req(bit nat, bit rd, bit nobuf, logic [19:0] a, int len,
                         int kind_exp, int n_reply, int bad_pos,
                         int drain_limit, bit poke, string hdr_tag);
    byte unsigned exp_tx[$];
    byte unsigned pay[$];
    int pi, cnt, pos, good;
    bit halted, out_exp;
    byte unsigned wd, wi;
    step();
    req_native = nat; req_read = rd; req_nobuf = nobuf;
    req_addr = a; req_len = 8'(len); req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    if (kind_exp != 0) begin
      chk("R9 done", done, 1);
      chk((kind_exp == 1) ? "R4 kind" : "R3 kind", done_kind, kind_exp);
      chk("R3 busy", busy, 0);
      chk("R4 go", go, 0);
      step();
      chk("R9 done falls", done, 0);
      chk("R3 nothing loaded", tx_valid, 0);
      chk("R3 busy after", busy, 0);
      return;
    end
    chk("R8 busy rise", busy, 1);
    for (int i = 0; i < len; i++) pay.push_back(8'(a[7:0] + 3 * i + 1));
    exp_tx.push_back({3'b000, rd, a[19:16]});
    exp_tx.push_back(a[15:8]);
    exp_tx.push_back(a[7:0]);
    exp_tx.push_back(8'(len - 1));
    if (!rd) for (int i = 0; i < len; i++) exp_tx.push_back(pay[i]);
    pi = 0;
    cnt = 0;
    while (!go && cnt < 400) begin
      if (pl_ready && pi < len) begin
        pl_valid = 1'b1; pl_data = pay[pi]; pi++;
      end else begin
        pl_valid = 1'b0;
      end
      step();
      cnt++;
    end
    pl_valid = 1'b0;
    chk("R5 go seen", go, 1);
    chk("R2 payload taken", pi, rd ? 0 : len);
    chk("R5 i2c flag", go_i2c, !nat);
    chk("R5 no_addr flag", go_no_addr, !nat);
    chk("R5 no_stop flag", go_no_stop, !nat && !rd);
    step();
    chk("R5 go one cycle", go, 0);
    cnt = 0;
    while (exp_tx.size() > 0 && cnt < drain_limit) begin
      chk((cnt < 4) ? {hdr_tag, " tx valid"} : "R2 tx valid", tx_valid, 1);
      chk((cnt < 4) ? {hdr_tag, " header byte"} : "R2 payload byte",
          tx_data, exp_tx[0]);
      void'(exp_tx.pop_front());
      tx_ready = 1'b1;
      step();
      cnt++;
    end
    tx_ready = 1'b0;
    if (exp_tx.size() == 0) chk("R2 fifo exhausted", tx_valid, 0);
    if (poke) begin
      req_native = 1'b1; req_len = 8'd0; req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      chk("R8 request ignored", done, 0);
      chk("R8 still busy", busy, 1);
    end
    pos = 0; halted = 0; good = 0;
    if (rd) begin
      for (int k = 0; k < n_reply; k++) begin
        wd = 8'(8'hA0 ^ (k * 7));
        if (k == 0) wi = 8'hEE;
        else if (k - 1 == bad_pos) wi = 8'(k - 1 + 8'h40);
        else wi = 8'(k - 1);
        out_exp = 0;
        if (k > 0 && !halted && pos < len) begin
          if (wi == pos) begin out_exp = 1; pos++; good++; end
          else halted = 1;
        end
        rx_valid = 1'b1; rx_data = wd; rx_idx = wi;
        step();
        chk("R7 rsp valid", rsp_valid, out_exp);
        if (out_exp) chk("R7 rsp data", rsp_data, wd);
      end
      rx_valid = 1'b0;
      step();
      chk("R7 rsp quiet", rsp_valid, 0);
    end
    ln_done = 1'b1;
    step();
    ln_done = 1'b0;
    chk("R9 done", done, 1);
    chk("R9 kind", done_kind, 0);
    chk("R7 count", done_count, rd ? good : len);
    chk("R8 busy fall", busy, 0);
    step();
    chk("R9 done pulse", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    chk("R8 reset busy", busy, 0);
    chk("R5 reset go", go, 0);
    chk("R9 reset done", done, 0);
    chk("R2 reset tx", tx_valid, 0);
    chk("R2 reset pl", pl_ready, 0);

    run_req(1, 0, 0, 20'h12345, 4, 0, 0, -1, 999, 0, "R1");
    run_req(1, 1, 0, 20'hF0000, 16, 0, 17, -1, 999, 0, "R1");
    run_req(1, 0, 0, 20'h00210, 16, 0, 0, -1, 999, 0, "R1");
    run_req(0, 1, 0, 20'h00050, 128, 0, 129, -1, 999, 0, "R1");
    run_req(0, 0, 0, 20'h00050, 124, 0, 0, -1, 999, 0, "R1");
    run_req(0, 0, 0, 20'h00050, 125, 2, 0, -1, 999, 0, "R3");
    run_req(1, 1, 0, 20'h00100, 17, 2, 0, -1, 999, 0, "R3");
    run_req(0, 1, 0, 20'h00050, 129, 2, 0, -1, 999, 0, "R3");
    run_req(1, 0, 0, 20'h00100, 0, 1, 0, -1, 999, 0, "R4");
    run_req(0, 1, 1, 20'h00100, 200, 1, 0, -1, 999, 0, "R4");
    run_req(0, 1, 0, 20'h00050, 10, 0, 11, 5, 999, 0, "R1");
    run_req(1, 1, 0, 20'h0ABCD, 8, 0, 4, -1, 999, 0, "R1");
    run_req(0, 0, 0, 20'h00037, 8, 0, 0, -1, 2, 1, "R1");
    run_req(1, 1, 0, 20'h54321, 2, 0, 3, -1, 999, 0, "R6");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule